// File: doc/BRIEF.md
# Interrupt Exception Entry Sequencer

This block carries out the processor-side hardware steps that begin once an interrupt request has been passed to the CPU. It does not act on the request until the current instruction has ended or the current exception sequence has ended, which is signalled on `boundary_i`. At that point it captures the vector number, the program counter, the condition register and the stack pointer. It then pushes the program counter and the condition register onto a descending stack through a single memory port. After that it writes back the condition register with the global interrupt mask bit set, so that only the non-maskable source can interrupt the handler.

Next it reads the vector table word at the address formed from the vector number and loads that word into the program counter. It closes the sequence with a one-cycle acknowledge to the interrupt controller that carries the serviced vector number. While `busy_o` is high the surrounding core stalls instruction issue. Every memory access is held stable until the memory raises its ready signal.

Top module: `irq_entry_seq`

## Requirements
- R1: After reset, `busy_o`, `mem_req_o`, `ccr_we_o`, `sp_we_o`, `pc_load_o` and `ack_o` are all 0.
- R2: A request with `boundary_i` low is not started: `busy_o` and `mem_req_o` stay 0 for as long as `boundary_i` stays low.
- R3: The vector number is captured on the clock edge where `req_i` and `boundary_i` are both high while idle. Later changes of `vec_i` have no effect on the fetch address or on `ack_vec_o`.
- R4: The first memory access is a write (`mem_we_o`=1) of the captured PC to address SP-2. The second is a write of the captured condition register, zero-extended to 16 bits, to address SP-4. SP here is the captured stack pointer, and arithmetic is modulo 2^16.
- R5: After both writes and before the table read, `ccr_we_o` pulses for one cycle with `ccr_o` equal to the captured condition register with bit 7 set and all other bits unchanged.
- R6: The third and last access is a read (`mem_we_o`=0) at address vector number × 2.
- R7: `pc_load_o` pulses for one cycle with `pc_o` equal to the word returned by that read.
- R8: `ack_o` pulses for one cycle, in the same cycle as `pc_load_o`, with `ack_vec_o` equal to the captured vector number. There is exactly one pulse per sequence.
- R9: `sp_we_o` pulses once per sequence with `sp_o` equal to the captured SP minus 4.
- R10: While `mem_req_o` is high and `mem_rdy_i` is low, the next cycle keeps `mem_req_o`, `mem_we_o`, `mem_addr_o` and `mem_wdata_o` unchanged.
- R11: `pc_i`, `ccr_i` and `sp_i` are captured at the start. Changes after the start do not alter any pushed or written-back value.
- R12: `busy_o` is high from the cycle after the start through the cycle of the acknowledge, and low otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_i | input | 1 | Interrupt request from the controller |
| vec_i | input | 6 | Vector number of the request |
| boundary_i | input | 1 | Current instruction or exception sequence ends this cycle |
| pc_i | input | 16 | Address of the next instruction |
| ccr_i | input | 8 | Current condition register |
| sp_i | input | 16 | Current stack pointer |
| mem_req_o | output | 1 | Memory access request |
| mem_we_o | output | 1 | 1 = write, 0 = read |
| mem_addr_o | output | 16 | Memory byte address |
| mem_wdata_o | output | 16 | Write data |
| mem_rdata_i | input | 16 | Read data, valid with ready |
| mem_rdy_i | input | 1 | Access completes this cycle |
| busy_o | output | 1 | Sequence in progress |
| sp_we_o | output | 1 | Stack pointer update strobe |
| sp_o | output | 16 | New stack pointer |
| ccr_we_o | output | 1 | Condition register update strobe |
| ccr_o | output | 8 | Condition register with mask bit set |
| pc_load_o | output | 1 | Program counter load strobe |
| pc_o | output | 16 | Handler address |
| ack_o | output | 1 | Acknowledge to the interrupt controller |
| ack_vec_o | output | 6 | Vector number being acknowledged |

## Verification
The bench holds a request while the boundary signal stays low. A design that started early would raise `busy_o` or access memory in the middle of an instruction. The vector, PC, flags and stack pointer inputs are changed right after the start. A design that did not capture them would push wrong values or fetch the wrong vector. Memory ready is delayed by several cycles to catch addresses or data that drift during a stall, or a state machine that moves on without ready. A stack pointer of 0x0002 checks the wrap past zero, and a flags value that already has the mask set checks that the other bits survive. Event cycle stamps check that the mask write lands after both pushes and before the table read.

// File: rtl/irq_entry_pkg.sv
package irq_entry_pkg;

  typedef enum logic [2:0] {
    S_IDLE     = 3'd0,
    S_PUSH_PC  = 3'd1,
    S_PUSH_CCR = 3'd2,
    S_MASK     = 3'd3,
    S_FETCH    = 3'd4,
    S_DONE     = 3'd5
  } seq_state_e;

endpackage

// File: rtl/ies_fsm.sv
module ies_fsm
  import irq_entry_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       req_i,
  input  logic       boundary_i,
  input  logic       mem_rdy_i,
  output seq_state_e state_o,
  output logic       start_o,
  output logic       adv_o,
  output logic       mem_req_o,
  output logic       mem_we_o
);

  seq_state_e state_q, state_d;

  always_comb begin
    start_o   = (state_q == S_IDLE) && req_i && boundary_i;
    mem_req_o = (state_q == S_PUSH_PC) || (state_q == S_PUSH_CCR) || (state_q == S_FETCH);
    mem_we_o  = (state_q == S_PUSH_PC) || (state_q == S_PUSH_CCR);
    adv_o     = mem_req_o && mem_rdy_i;
  end

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      S_IDLE:     if (start_o) state_d = S_PUSH_PC;
      S_PUSH_PC:  if (adv_o)   state_d = S_PUSH_CCR;
      S_PUSH_CCR: if (adv_o)   state_d = S_MASK;
      S_MASK:                  state_d = S_FETCH;
      S_FETCH:    if (adv_o)   state_d = S_DONE;
      S_DONE:                  state_d = S_IDLE;
      default:                 state_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= S_IDLE;
    else        state_q <= state_d;
  end

  assign state_o = state_q;

  // R2: no entry unless the current instruction has ended
  a_r2_wait_boundary: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == S_IDLE && !boundary_i) |=> (state_q == S_IDLE));

  // R7: the load state lasts one cycle
  a_r7_load_once: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == S_DONE) |=> (state_q == S_IDLE));

endmodule

// File: rtl/ies_datapath.sv
module ies_datapath
  import irq_entry_pkg::*;
#(
  parameter int WORD_W   = 16,
  parameter int VEC_W    = 6,
  parameter int CCR_W    = 8,
  parameter int MASK_BIT = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  seq_state_e        state_i,
  input  logic              start_i,
  input  logic              adv_i,
  input  logic [VEC_W-1:0]  vec_i,
  input  logic [WORD_W-1:0] pc_i,
  input  logic [CCR_W-1:0]  ccr_i,
  input  logic [WORD_W-1:0] sp_i,
  input  logic [WORD_W-1:0] mem_rdata_i,
  output logic [WORD_W-1:0] mem_addr_o,
  output logic [WORD_W-1:0] mem_wdata_o,
  output logic [WORD_W-1:0] sp_o,
  output logic [CCR_W-1:0]  ccr_o,
  output logic [WORD_W-1:0] pc_o,
  output logic [VEC_W-1:0]  ack_vec_o
);

  localparam int STEP  = WORD_W / 8;
  localparam int SHIFT = $clog2(STEP);
  localparam logic [WORD_W-1:0] STEP_W = WORD_W'(STEP);
  localparam logic [CCR_W-1:0]  MASK_V = CCR_W'(1) << MASK_BIT;

  logic [VEC_W-1:0]  vec_q, vec_d;
  logic [WORD_W-1:0] pc_q, pc_d;
  logic [CCR_W-1:0]  ccr_q, ccr_d;
  logic [WORD_W-1:0] sp_q, sp_d;
  logic [WORD_W-1:0] tgt_q, tgt_d;
  logic              push_adv;
  logic [WORD_W-1:0] sp_dec;
  logic [WORD_W-1:0] vec_addr;

  always_comb begin
    push_adv = adv_i && ((state_i == S_PUSH_PC) || (state_i == S_PUSH_CCR));
    sp_dec   = sp_q - STEP_W;
    vec_addr = WORD_W'(vec_q) << SHIFT;

    vec_d = start_i ? vec_i : vec_q;
    pc_d  = start_i ? pc_i  : pc_q;
    ccr_d = start_i ? ccr_i : ccr_q;
    if (start_i)       sp_d = sp_i;
    else if (push_adv) sp_d = sp_dec;
    else               sp_d = sp_q;
    tgt_d = (adv_i && state_i == S_FETCH) ? mem_rdata_i : tgt_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vec_q <= '0;
      pc_q  <= '0;
      ccr_q <= '0;
      sp_q  <= '0;
      tgt_q <= '0;
    end else begin
      vec_q <= vec_d;
      pc_q  <= pc_d;
      ccr_q <= ccr_d;
      sp_q  <= sp_d;
      tgt_q <= tgt_d;
    end
  end

  always_comb begin
    mem_addr_o  = '0;
    mem_wdata_o = '0;
    unique case (state_i)
      S_PUSH_PC: begin
        mem_addr_o  = sp_dec;
        mem_wdata_o = pc_q;
      end
      S_PUSH_CCR: begin
        mem_addr_o  = sp_dec;
        mem_wdata_o = {{(WORD_W-CCR_W){1'b0}}, ccr_q};
      end
      S_FETCH: mem_addr_o = vec_addr;
      default: ;
    endcase
  end

  assign sp_o      = sp_q;
  assign ccr_o     = ccr_q | MASK_V;
  assign pc_o      = tgt_q;
  assign ack_vec_o = vec_q;

  // R3: captured vector only changes at a start
  a_r3_vec_held: assert property (@(posedge clk) disable iff (!rst_n)
    !start_i |=> $stable(vec_q));

  // R11: captured PC and flags only change at a start
  a_r11_ctx_held: assert property (@(posedge clk) disable iff (!rst_n)
    !start_i |=> ($stable(pc_q) && $stable(ccr_q)));

endmodule

// File: rtl/irq_entry_seq.sv
module irq_entry_seq
  import irq_entry_pkg::*;
#(
  parameter int WORD_W   = 16,
  parameter int VEC_W    = 6,
  parameter int CCR_W    = 8,
  parameter int MASK_BIT = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_i,
  input  logic [VEC_W-1:0]  vec_i,
  input  logic              boundary_i,
  input  logic [WORD_W-1:0] pc_i,
  input  logic [CCR_W-1:0]  ccr_i,
  input  logic [WORD_W-1:0] sp_i,
  output logic              mem_req_o,
  output logic              mem_we_o,
  output logic [WORD_W-1:0] mem_addr_o,
  output logic [WORD_W-1:0] mem_wdata_o,
  input  logic [WORD_W-1:0] mem_rdata_i,
  input  logic              mem_rdy_i,
  output logic              busy_o,
  output logic              sp_we_o,
  output logic [WORD_W-1:0] sp_o,
  output logic              ccr_we_o,
  output logic [CCR_W-1:0]  ccr_o,
  output logic              pc_load_o,
  output logic [WORD_W-1:0] pc_o,
  output logic              ack_o,
  output logic [VEC_W-1:0]  ack_vec_o
);

  seq_state_e state;
  logic       start;
  logic       adv;

  ies_fsm u_fsm (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_i      (req_i),
    .boundary_i (boundary_i),
    .mem_rdy_i  (mem_rdy_i),
    .state_o    (state),
    .start_o    (start),
    .adv_o      (adv),
    .mem_req_o  (mem_req_o),
    .mem_we_o   (mem_we_o)
  );

  ies_datapath #(
    .WORD_W   (WORD_W),
    .VEC_W    (VEC_W),
    .CCR_W    (CCR_W),
    .MASK_BIT (MASK_BIT)
  ) u_dp (
    .clk         (clk),
    .rst_n       (rst_n),
    .state_i     (state),
    .start_i     (start),
    .adv_i       (adv),
    .vec_i       (vec_i),
    .pc_i        (pc_i),
    .ccr_i       (ccr_i),
    .sp_i        (sp_i),
    .mem_rdata_i (mem_rdata_i),
    .mem_addr_o  (mem_addr_o),
    .mem_wdata_o (mem_wdata_o),
    .sp_o        (sp_o),
    .ccr_o       (ccr_o),
    .pc_o        (pc_o),
    .ack_vec_o   (ack_vec_o)
  );

  assign busy_o    = (state != S_IDLE);
  assign sp_we_o   = (state == S_MASK);
  assign ccr_we_o  = (state == S_MASK);
  assign pc_load_o = (state == S_DONE);
  assign ack_o     = (state == S_DONE);

  // R10: a stalled access is held unchanged
  a_r10_stall_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_o && !mem_rdy_i) |=> (mem_req_o && $stable(mem_we_o) &&
                                   $stable(mem_addr_o) && $stable(mem_wdata_o)));

  // R5: the written-back flags always carry the mask bit
  a_r5_mask_set: assert property (@(posedge clk) disable iff (!rst_n)
    ccr_we_o |-> ccr_o[MASK_BIT]);

  // R8: acknowledge is a single-cycle pulse
  a_r8_ack_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    ack_o |=> !ack_o);

  // R12: no memory traffic while not busy
  a_r12_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_o |-> !mem_req_o);

endmodule

// File: tb/tb_irq_entry_seq.sv
module tb_irq_entry_seq;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        req_i, boundary_i, mem_rdy_i;
  logic [5:0]  vec_i;
  logic [15:0] pc_i, sp_i, mem_rdata_i;
  logic [7:0]  ccr_i;
  logic        mem_req_o, mem_we_o, busy_o, sp_we_o, ccr_we_o, pc_load_o, ack_o;
  logic [15:0] mem_addr_o, mem_wdata_o, sp_o, pc_o;
  logic [7:0]  ccr_o;
  logic [5:0]  ack_vec_o;

  always #2 clk = ~clk;

  irq_entry_seq dut (
    .clk(clk), .rst_n(rst_n), .req_i(req_i), .vec_i(vec_i), .boundary_i(boundary_i),
    .pc_i(pc_i), .ccr_i(ccr_i), .sp_i(sp_i),
    .mem_req_o(mem_req_o), .mem_we_o(mem_we_o), .mem_addr_o(mem_addr_o),
    .mem_wdata_o(mem_wdata_o), .mem_rdata_i(mem_rdata_i), .mem_rdy_i(mem_rdy_i),
    .busy_o(busy_o), .sp_we_o(sp_we_o), .sp_o(sp_o), .ccr_we_o(ccr_we_o), .ccr_o(ccr_o),
    .pc_load_o(pc_load_o), .pc_o(pc_o), .ack_o(ack_o), .ack_vec_o(ack_vec_o)
  );

  int n_chk = 0;
  int n_bad = 0;

  // memory model: ready after wait_n stall cycles, read data derived from address
  int wait_n = 0;
  int stall_cnt = 0;
  always @(posedge clk) begin
    if (!mem_req_o || mem_rdy_i) stall_cnt <= 0;
    else                         stall_cnt <= stall_cnt + 1;
  end
  assign mem_rdy_i   = mem_req_o && (stall_cnt >= wait_n);
  assign mem_rdata_i = mem_addr_o ^ 16'hA5C3;

  // event log
  int          cyc = 0;
  int          wr_n, rd_n, ccr_n, sp_n, ack_n, stall_bad;
  logic [15:0] wr_a [4];
  logic [15:0] wr_d [4];
  int          wr_cyc, rd_cyc, ccr_cyc;
  logic [15:0] rd_a, sp_v;
  logic [7:0]  ccr_v;
  logic        prev_stall;
  logic [15:0] prev_a, prev_d;
  logic        prev_we;

  task automatic clear_log();
    wr_n = 0; rd_n = 0; ccr_n = 0; sp_n = 0; ack_n = 0; stall_bad = 0;
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (rst_n) begin
      if (prev_stall && (!mem_req_o || mem_addr_o != prev_a ||
                         mem_wdata_o != prev_d || mem_we_o != prev_we))
        stall_bad = stall_bad + 1;
      prev_stall = mem_req_o && !mem_rdy_i;
      prev_a = mem_addr_o; prev_d = mem_wdata_o; prev_we = mem_we_o;
      if (mem_req_o && mem_rdy_i && mem_we_o) begin
        if (wr_n < 4) begin wr_a[wr_n] = mem_addr_o; wr_d[wr_n] = mem_wdata_o; end
        wr_n = wr_n + 1; wr_cyc = cyc;
      end
      if (mem_req_o && mem_rdy_i && !mem_we_o) begin
        rd_n = rd_n + 1; rd_a = mem_addr_o; rd_cyc = cyc;
      end
      if (ccr_we_o) begin ccr_n = ccr_n + 1; ccr_v = ccr_o; ccr_cyc = cyc; end
      if (sp_we_o)  begin sp_n = sp_n + 1; sp_v = sp_o; end
      if (ack_o)    ack_n = ack_n + 1;
    end else begin
      prev_stall = 1'b0;
    end
  end

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic t_reset();
    rst_n = 1'b0; req_i = 0; boundary_i = 0; vec_i = 0; pc_i = 0; ccr_i = 0; sp_i = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check({busy_o, mem_req_o, ccr_we_o, sp_we_o, pc_load_o, ack_o} == 6'b0, "R1",
          "outputs after reset", {busy_o, mem_req_o, ccr_we_o, sp_we_o, pc_load_o, ack_o}, 0);
  endtask

  task automatic t_no_boundary();
    bit seen = 0;
    clear_log();
    req_i = 1; vec_i = 6'd9; boundary_i = 0;
    repeat (12) begin
      @(negedge clk);
      if (busy_o || mem_req_o) seen = 1;
    end
    check(!seen, "R2", "activity while boundary low", seen, 0);
    check(wr_n == 0 && rd_n == 0, "R2", "memory accesses", wr_n + rd_n, 0);
    req_i = 0;
  endtask

  task automatic run_entry(input logic [5:0] v, input logic [15:0] pc,
                           input logic [7:0] cc, input logic [15:0] sp,
                           input int wt, input bit scramble);
    int tmo = 0;
    logic [15:0] e_sp2, e_sp4, e_pc;
    wait_n = wt;
    clear_log();
    e_sp2 = sp - 16'd2; e_sp4 = sp - 16'd4;
    e_pc  = {9'd0, v, 1'b0} ^ 16'hA5C3;
    req_i = 1; boundary_i = 1; vec_i = v; pc_i = pc; ccr_i = cc; sp_i = sp;
    @(negedge clk);
    req_i = 0; boundary_i = 0;
    if (scramble) begin
      vec_i = ~v; pc_i = ~pc; ccr_i = ~cc; sp_i = sp ^ 16'h0F0F;
    end
    check(busy_o, "R12", "busy after start", busy_o, 1);
    while (!ack_o && tmo < 300) begin
      @(negedge clk);
      tmo++;
      if (!ack_o) check(busy_o, "R12", "busy during sequence", busy_o, 1);
    end
    check(ack_o, "R8", "acknowledge seen", ack_o, 1);
    check(pc_load_o, "R8", "ack with pc load", pc_load_o, 1);
    check(ack_vec_o == v, "R3", "ack vector", ack_vec_o, v);
    check(pc_o == e_pc, "R7", "loaded pc", pc_o, e_pc);
    check(busy_o, "R12", "busy in ack cycle", busy_o, 1);
    @(negedge clk);
    check(!ack_o && !pc_load_o, "R7", "single-cycle load/ack", {ack_o, pc_load_o}, 0);
    check(!busy_o, "R12", "idle after ack", busy_o, 0);
    check(ack_n == 1, "R8", "ack pulse count", ack_n, 1);
    check(wr_n == 2, "R4", "write count", wr_n, 2);
    check(wr_a[0] == e_sp2 && wr_d[0] == pc, "R4", "pc push addr/data",
          {wr_a[0], wr_d[0]}, {e_sp2, pc});
    check(wr_a[1] == e_sp4 && wr_d[1] == {8'd0, cc}, "R11", "ccr push addr/data",
          {wr_a[1], wr_d[1]}, {e_sp4, 8'd0, cc});
    check(ccr_n == 1 && ccr_v == (cc | 8'h80), "R5", "mask write-back", ccr_v, cc | 8'h80);
    check(ccr_cyc > wr_cyc && ccr_cyc < rd_cyc, "R5", "mask write order",
          ccr_cyc, wr_cyc + 1);
    check(rd_n == 1 && rd_a == {9'd0, v, 1'b0}, "R6", "vector fetch address",
          rd_a, {9'd0, v, 1'b0});
    check(sp_n == 1 && sp_v == e_sp4, "R9", "stack pointer update", sp_v, e_sp4);
    check(stall_bad == 0, "R10", "stall stability", stall_bad, 0);
  endtask

  initial begin
    t_reset();
    t_no_boundary();
    run_entry(6'd9,  16'h1234, 8'h05, 16'hFF80, 0, 0);
    run_entry(6'd17, 16'h4A4E, 8'h2A, 16'h8000, 3, 0);
    run_entry(6'd63, 16'hBEEF, 8'h80, 16'h0002, 2, 1);
    run_entry(6'd1,  16'h0100, 8'hC3, 16'hF000, 5, 1);
    run_entry(6'd0,  16'hFFFE, 8'h7F, 16'h0000, 1, 0);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #400000;
    n_bad++; n_chk++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule